// File: doc/BRIEF.md
# Strobed Input Handshake Port

An 8-bit input port that takes data from a peripheral under a two-wire handshake. The peripheral puts a byte on the port pins and drives an active-low strobe. While the strobe is low the port copies the pins into a holding latch and raises a buffer-full flag. Once the strobe is released, the port can raise an interrupt request to the CPU. An interrupt-enable flop gates that request.

The CPU reads the held byte and pulses an active-low read strobe. The falling edge of the read strobe withdraws the interrupt request. The rising edge clears buffer-full. The interrupt-enable flop is written by a bit set/reset command. The command carries a control-port bit index and a value, and only the index given by a parameter reaches the flop. Set that parameter to 4 for the A-side instance and to 2 for the B-side instance.

The peripheral strobe, the read strobe and the pins pass through the same synchroniser stages. Edges are found by comparing each synchronised sample with the one before it.

Top module: `strobe_in_port`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears data_o to 0x00, full_o to 0, irq_o to 0 and the interrupt-enable flop to 0. After reset, a complete strobe cycle leaves irq_o at 0.
- R2: While stb_ni is low, data_o takes the value on pins_i. The new value appears on the third rising clock edge after the inputs change (two synchroniser stages plus the latch), and not on the second.
- R3: While stb_ni is high, data_o holds its value whatever pins_i does.
- R4: full_o goes to 1 with the same latency as data_o when stb_ni is low.
- R5: full_o clears on a rising edge of rd_ni. A falling edge of rd_ni leaves it set.
- R6: irq_o rises only while the synchronised strobe is high, full_o is 1, the interrupt-enable flop is 1 and the read strobe is idle. It does not rise while stb_ni is still low.
- R7: A falling edge of rd_ni clears irq_o. irq_o does not rise again before the next peripheral strobe.
- R8: A command with bsr_we_i=1 writes bsr_val_i into the interrupt-enable flop only when bsr_sel_i equals INTE_BIT (default 4). Commands aimed at any other index leave the flop unchanged.
- R9: Writing 0 into the interrupt-enable flop drops irq_o on the next clock edge.
- R10: A new strobe while full_o is 1 overwrites data_o. full_o stays 1.
- R11: With the interrupt-enable flop at 0, a completed strobe sets full_o but leaves irq_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Peripheral data pins |
| stb_ni | input | 1 | Peripheral strobe, active low |
| rd_ni | input | 1 | CPU read strobe, active low |
| bsr_we_i | input | 1 | Bit set/reset command valid |
| bsr_sel_i | input | 3 | Control-port bit index of the command |
| bsr_val_i | input | 1 | Value written by the command |
| data_o | output | 8 | Held data byte |
| full_o | output | 1 | Buffer-full flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck or wrongly written interrupt-enable flop has no output of its own. It shows up only on irq_o, one clock after the next moment the set condition holds, so the bench pairs every enable command with a buffer-full state that exposes it. A lost read-strobe edge appears as full_o or irq_o staying high three clocks after the read strobe changes. A latch that captures while the strobe is high appears on data_o within three clocks of a pin change. Checks are timed to the exact edge, so a wrong synchroniser depth is caught as a latency error.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t find_edge(logic cur, logic prev);
    edge_t e;
    e.rise = cur & ~prev;
    e.fall = ~cur & prev;
    return e;
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int             W       = 10,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sp_latch.sv
module sp_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
endmodule

// File: rtl/sp_hs_ctrl.sv
module sp_hs_ctrl
  import sp_pkg::*;
#(
  parameter int CTRL_IDX_W = 3,
  parameter int INTE_BIT   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  s_stb_i,
  input  logic                  s_rd_i,
  input  logic                  bsr_we_i,
  input  logic [CTRL_IDX_W-1:0] bsr_sel_i,
  input  logic                  bsr_val_i,
  output logic                  cap_o,
  output logic                  full_o,
  output logic                  irq_o,
  output logic                  inte_o,
  output logic                  rd_prev_o
);
  localparam logic [CTRL_IDX_W-1:0] INTE_SEL = CTRL_IDX_W'(INTE_BIT);

  edge_t rd_e;
  logic  irq_set;

  assign rd_e    = find_edge(s_rd_i, rd_prev_o);
  assign cap_o   = ~s_stb_i;
  // read must be idle for two samples so a rising read edge cannot re-arm
  assign irq_set = s_stb_i & full_o & inte_o & s_rd_i & rd_prev_o;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rd_prev_o <= 1'b1;
    else         rd_prev_o <= s_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            full_o <= 1'b0;
    else if (!s_stb_i)      full_o <= 1'b1;
    else if (rd_e.rise)     full_o <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                inte_o <= 1'b0;
    else if (bsr_we_i && bsr_sel_i == INTE_SEL) inte_o <= bsr_val_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  irq_o <= 1'b0;
    else if (!inte_o || rd_e.fall) irq_o <= 1'b0;
    else if (irq_set)             irq_o <= 1'b1;
endmodule

// File: rtl/strobe_in_port.sv
module strobe_in_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_IDX_W  = 3,
  parameter int INTE_BIT    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_W-1:0]     pins_i,
  input  logic                  stb_ni,
  input  logic                  rd_ni,
  input  logic                  bsr_we_i,
  input  logic [CTRL_IDX_W-1:0] bsr_sel_i,
  input  logic                  bsr_val_i,
  output logic [DATA_W-1:0]     data_o,
  output logic                  full_o,
  output logic                  irq_o
);
  localparam int            SW      = DATA_W + 2;
  localparam logic [SW-1:0] SYN_RST = {2'b11, {DATA_W{1'b0}}};

  logic [SW-1:0]     syn_q;
  logic [DATA_W-1:0] s_pins;
  logic              s_stb, s_rd, rd_prev, inte_q, cap;

  sp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({stb_ni, rd_ni, pins_i}),
    .q_o   (syn_q)
  );

  assign {s_stb, s_rd, s_pins} = syn_q;

  sp_hs_ctrl #(.CTRL_IDX_W(CTRL_IDX_W), .INTE_BIT(INTE_BIT)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .s_stb_i  (s_stb),
    .s_rd_i   (s_rd),
    .bsr_we_i (bsr_we_i),
    .bsr_sel_i(bsr_sel_i),
    .bsr_val_i(bsr_val_i),
    .cap_o    (cap),
    .full_o   (full_o),
    .irq_o    (irq_o),
    .inte_o   (inte_q),
    .rd_prev_o(rd_prev)
  );

  sp_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .d_i   (s_pins),
    .q_o   (data_o)
  );
endmodule

// File: rtl/strobe_in_port_chk.sv
module strobe_in_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_stb,
  input logic              s_rd,
  input logic              rd_prev,
  input logic              inte_q,
  input logic [DATA_W-1:0] data_o,
  input logic              full_o,
  input logic              irq_o
);
  a_r4_full_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_stb |=> full_o);

  a_r5_full_clears_on_rd_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(s_rd && !rd_prev));

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_stb |=> $stable(data_o));

  a_r6_irq_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(s_stb && full_o && inte_q));

  a_r7_irq_drop_on_rd_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_rd && rd_prev) |=> !irq_o);

  a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inte_q |=> !irq_o);
endmodule

bind strobe_in_port strobe_in_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .s_stb  (s_stb),
  .s_rd   (s_rd),
  .rd_prev(rd_prev),
  .inte_q (inte_q),
  .data_o (data_o),
  .full_o (full_o),
  .irq_o  (irq_o)
);

// File: tb/strobe_in_port_tb.sv
module strobe_in_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pins_i = 8'h00;
  logic       stb_ni = 1'b1;
  logic       rd_ni = 1'b1;
  logic       bsr_we_i = 1'b0;
  logic [2:0] bsr_sel_i = 3'd0;
  logic       bsr_val_i = 1'b0;
  logic [7:0] data_o;
  logic       full_o, irq_o;

  strobe_in_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .stb_ni(stb_ni),
    .rd_ni(rd_ni), .bsr_we_i(bsr_we_i), .bsr_sel_i(bsr_sel_i),
    .bsr_val_i(bsr_val_i), .data_o(data_o), .full_o(full_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    int         cyc;
    string      req;
    logic [7:0] d;
    logic       f;
    logic       i;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic compare(string req, logic [7:0] d, logic f, logic i);
    n_chk++;
    if (data_o !== d || full_o !== f || irq_o !== i) begin
      n_fail++;
      $display("FAIL %s: data=%h full=%b irq=%b expected data=%h full=%b irq=%b",
               req, data_o, full_o, irq_o, d, f, i);
    end
  endtask

  // driver side: schedule an expectation k posedges from now
  task automatic push(int k, string req, logic [7:0] d, logic f, logic i);
    exp_t e;
    e.cyc = cyc + k; e.req = req; e.d = d; e.f = f; e.i = i;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bsr(logic [2:0] sel, logic val);
    bsr_we_i = 1'b1; bsr_sel_i = sel; bsr_val_i = val;
    idle(1);
    bsr_we_i = 1'b0;
  endtask

  // monitor: pop due expectations away from the active edge
  initial forever begin
    @(negedge clk_i);
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      compare(e.req, e.d, e.f, e.i);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run=hung expected=complete");
    finish_run();
  end

  initial begin
    idle(2);
    compare("R1 reset state", 8'h00, 1'b0, 1'b0);
    rst_ni = 1'b1;
    idle(2);

    // R2/R4: capture latency
    pins_i = 8'hA5; stb_ni = 1'b0;
    push(2, "R2 not before third edge", 8'h00, 1'b0, 1'b0);
    push(3, "R2 R4 capture", 8'hA5, 1'b1, 1'b0);
    idle(4);
    // R3/R11: release with pins changing, enable still clear
    stb_ni = 1'b1; pins_i = 8'h3C;
    push(4, "R3 R11 hold, no irq", 8'hA5, 1'b1, 1'b0);
    idle(5);
    // R5: read cycle
    rd_ni = 1'b0;
    push(3, "R5 fall keeps full", 8'hA5, 1'b1, 1'b0);
    idle(4);
    rd_ni = 1'b1;
    push(3, "R5 rise clears full", 8'hA5, 1'b0, 1'b0);
    idle(4);

    // R8: enable via index 4
    bsr(3'd4, 1'b1);
    idle(2);
    // R6: no irq while strobe low, rises after release
    pins_i = 8'h5A; stb_ni = 1'b0;
    push(3, "R4 capture", 8'h5A, 1'b1, 1'b0);
    push(5, "R6 no irq while strobe low", 8'h5A, 1'b1, 1'b0);
    idle(6);
    stb_ni = 1'b1;
    push(2, "R6 not yet", 8'h5A, 1'b1, 1'b0);
    push(3, "R6 R8 irq rises", 8'h5A, 1'b1, 1'b1);
    idle(4);
    // R8: command to another index ignored
    bsr(3'd2, 1'b0);
    push(3, "R8 other index ignored", 8'h5A, 1'b1, 1'b1);
    idle(4);

    // R10: overwrite while full
    pins_i = 8'hC3; stb_ni = 1'b0;
    push(3, "R10 overwrite", 8'hC3, 1'b1, 1'b1);
    idle(4);
    stb_ni = 1'b1;
    idle(4);
    // R7: irq cleared by read fall, not re-raised
    rd_ni = 1'b0;
    push(3, "R7 irq clear on rd fall", 8'hC3, 1'b1, 1'b0);
    idle(4);
    rd_ni = 1'b1;
    push(3, "R5 full clear", 8'hC3, 1'b0, 1'b0);
    push(6, "R7 no re-raise", 8'hC3, 1'b0, 1'b0);
    idle(7);

    // R9: clearing enable drops irq
    pins_i = 8'h96; stb_ni = 1'b0;
    idle(4);
    stb_ni = 1'b1;
    push(4, "R6 irq up", 8'h96, 1'b1, 1'b1);
    idle(5);
    bsr(3'd4, 1'b0);
    push(1, "R9 irq drops", 8'h96, 1'b1, 1'b0);
    idle(3);

    // R1: reset mid-run clears everything incl. enable
    bsr(3'd4, 1'b1);
    idle(1);
    rst_ni = 1'b0;
    #1;
    compare("R1 async reset", 8'h00, 1'b0, 1'b0);
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    pins_i = 8'h77; stb_ni = 1'b0;
    idle(4);
    stb_ni = 1'b1;
    push(5, "R1 enable cleared by reset", 8'h77, 1'b1, 1'b0);
    idle(6);

    while (exp_q.size() > 0) idle(1);
    finish_run();
  end
endmodule